// File: doc/BRIEF.md
# Stallable Simple Dual-Port RAM

This block is a two-port memory: one port writes, the other reads. The write side registers a word, an address, a write strobe and a set of byte-lane enables. The read side registers an address and a read strobe, then drives a registered output word. A compile-time parameter picks how the two clock inputs are assigned to the block's register groups. The options are:

- one shared clock;
- a write clock and a read clock;
- an input clock and an output clock;
- one clock per port.

Each clock input comes with its own clock enable and its own asynchronous clear. The output word also has a synchronous clear. Each port has a hold input that freezes its registered address. A caller can therefore stall the address pipeline and still feed new data and strobes.

Clock, enable and clear are named primary (`_p`) and secondary (`_s`). The write-side registers and the storage always use the primary set. The `MODE` parameter decides which set drives the read-side input registers and the output register.

Top module: `sdp_ram_stall`

## Requirements
- R1: With `MODE` = SDPR_SINGLE, every register and the storage use `clk_p`, `ce_p` and `clr_p`. In that mode `clk_s`, `ce_s` and `clr_s` have no effect on `rd_data`.
- R2: With `MODE` = SDPR_PER_PORT or SDPR_RW_SPLIT, the read address, the read strobe and `rd_data` are registered on `clk_s` under `ce_s` and `clr_s`. With SDPR_IN_OUT, only `rd_data` uses the secondary set. Writes use the primary set in every mode.
- R3: Inputs are sampled at one active edge. If the sampled read strobe was 1, `rd_data` shows the word at the sampled read address after the next edge.
- R4: When the registered read strobe is 0 and no synchronous clear is applied, `rd_data` keeps its previous value.
- R5: If the same address is written and read at the same edge, `rd_data` returns the contents from before the write.
- R6: Byte lane i is bits [8*i+7 : 8*i] of the word (LANE_W = DATA_W/BE_W = 8 by default). Only lanes whose `wr_lane_en[i]` is 1 are updated. The other lanes keep their stored bits.
- R7: While `wr_en` is 0, no word of the storage changes.
- R8: While `wr_addr_hold` is 1 at an enabled edge, the write address register keeps its value. Data, strobe and lane enables still load.
- R9: While `rd_addr_hold` is 1 at an enabled edge, the read address register keeps its value. The read strobe still loads.
- R10: At an edge where a domain's clock enable is 0, no register of that domain changes. This includes storage writes in the primary domain.
- R11: A clear input set to 1 drives its domain's registers to zero right away: registered strobes, addresses and `rd_data`. The storage is not cleared.
- R12: If `out_sclr` is 1 at an enabled output edge, `rd_data` becomes 0. The clear takes priority over a pending read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_p | input | 1 | Primary clock |
| clk_s | input | 1 | Secondary clock |
| ce_p | input | 1 | Primary clock enable |
| ce_s | input | 1 | Secondary clock enable |
| clr_p | input | 1 | Asynchronous clear, primary domain |
| clr_s | input | 1 | Asynchronous clear, secondary domain |
| out_sclr | input | 1 | Synchronous clear of rd_data |
| wr_data | input | DATA_W | Write word |
| wr_addr | input | ADDR_W | Write address |
| wr_en | input | 1 | Write strobe |
| wr_lane_en | input | BE_W | Byte-lane write enables |
| wr_addr_hold | input | 1 | Freeze registered write address |
| rd_addr | input | ADDR_W | Read address |
| rd_en | input | 1 | Read strobe |
| rd_addr_hold | input | 1 | Freeze registered read address |
| rd_data | output | DATA_W | Registered read word |

## Verification
Several rules are checked by assertions on every edge:
- address freezing under hold;
- no write strobe after an idle `wr_en`;
- output hold when the read strobe is low;
- output hold when the enable is low;
- the synchronous clear forcing zero.

Other behaviour depends on the storage contents, so only the bench scenarios can show it. That covers returning old data on a read-during-write, byte-lane merging, reset values, and clock-enable gating in the per-port mode next to the single-clock mode. A bench reference model covers those scenarios over directed and seeded random traffic.

// File: rtl/sdpr_pkg.sv
package sdpr_pkg;

    typedef enum logic [1:0] {
        SDPR_SINGLE   = 2'd0,
        SDPR_RW_SPLIT = 2'd1,
        SDPR_IN_OUT   = 2'd2,
        SDPR_PER_PORT = 2'd3
    } clk_mode_e;

    // Read-side input registers follow the secondary clock
    function automatic logic rd_side_on_sec(clk_mode_e m);
        return (m == SDPR_RW_SPLIT) || (m == SDPR_PER_PORT);
    endfunction

    // Output register follows the secondary clock
    function automatic logic out_on_sec(clk_mode_e m);
        return m != SDPR_SINGLE;
    endfunction

endpackage

// File: rtl/sdpr_wr_port.sv
module sdpr_wr_port #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32,
    parameter int BE_W   = 4
) (
    input  logic              clk,
    input  logic              ce,
    input  logic              clr,
    input  logic              wen_i,
    input  logic              hold_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [BE_W-1:0]   be_i,
    output logic              wen_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_q,
    output logic [BE_W-1:0]   be_q
);

    always_ff @(posedge clk or posedge clr) begin
        if (clr) begin
            wen_q  <= 1'b0;
            addr_q <= '0;
            data_q <= '0;
            be_q   <= '0;
        end else if (ce) begin
            if (!hold_i) addr_q <= addr_i;
            wen_q  <= wen_i;
            data_q <= data_i;
            be_q   <= be_i;
        end
    end

    // R8: held address stays put
    a_r8_wr_addr_frozen: assert property (@(posedge clk) disable iff (clr)
        (ce && hold_i) |=> (addr_q == $past(addr_q)));

    // R7: idle write strobe yields no registered write
    a_r7_no_write_strobe: assert property (@(posedge clk) disable iff (clr)
        (ce && !wen_i) |=> !wen_q);

endmodule

// File: rtl/sdpr_rd_port.sv
module sdpr_rd_port #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              ce,
    input  logic              clr,
    input  logic              ren_i,
    input  logic              hold_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              ren_q,
    output logic [ADDR_W-1:0] addr_q
);

    always_ff @(posedge clk or posedge clr) begin
        if (clr) begin
            ren_q  <= 1'b0;
            addr_q <= '0;
        end else if (ce) begin
            if (!hold_i) addr_q <= addr_i;
            ren_q <= ren_i;
        end
    end

    // R9: held read address stays put
    a_r9_rd_addr_frozen: assert property (@(posedge clk) disable iff (clr)
        (ce && hold_i) |=> (addr_q == $past(addr_q)));

endmodule

// File: rtl/sdpr_lane_mem.sv
module sdpr_lane_mem #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32,
    parameter int BE_W   = 4
) (
    input  logic              wclk,
    input  logic              ce,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [BE_W-1:0]   be,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH  = 1 << ADDR_W;
    localparam int LANE_W = DATA_W / BE_W;

    for (genvar g = 0; g < BE_W; g++) begin : g_lane
        logic [LANE_W-1:0] store [DEPTH];

        always_ff @(posedge wclk) begin
            if (ce && we && be[g]) store[waddr] <= wdata[g*LANE_W +: LANE_W];
        end

        assign rdata[g*LANE_W +: LANE_W] = store[raddr];
    end

endmodule

// File: rtl/sdpr_out_reg.sv
module sdpr_out_reg #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              ce,
    input  logic              clr,
    input  logic              sclr,
    input  logic              load,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q
);

    always_ff @(posedge clk or posedge clr) begin
        if (clr)           q <= '0;
        else if (ce) begin
            if (sclr)      q <= '0;
            else if (load) q <= d;
        end
    end

    // R4: no read strobe, no change
    a_r4_hold_without_read: assert property (@(posedge clk) disable iff (clr)
        (ce && !sclr && !load) |=> $stable(q));

    // R12: synchronous clear zeroes the word
    a_r12_sclr_zeroes: assert property (@(posedge clk) disable iff (clr)
        (ce && sclr) |=> (q == '0));

    // R10: gated edge freezes the word
    a_r10_gated_hold: assert property (@(posedge clk) disable iff (clr)
        !ce |=> $stable(q));

endmodule

// File: rtl/sdp_ram_stall.sv
module sdp_ram_stall
    import sdpr_pkg::*;
#(
    parameter clk_mode_e MODE   = SDPR_SINGLE,
    parameter int        ADDR_W = 6,
    parameter int        DATA_W = 32,
    parameter int        BE_W   = 4
) (
    input  logic              clk_p,
    input  logic              clk_s,
    input  logic              ce_p,
    input  logic              ce_s,
    input  logic              clr_p,
    input  logic              clr_s,
    input  logic              out_sclr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_en,
    input  logic [BE_W-1:0]   wr_lane_en,
    input  logic              wr_addr_hold,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_en,
    input  logic              rd_addr_hold,
    output logic [DATA_W-1:0] rd_data
);

    localparam logic RD_SEC  = rd_side_on_sec(MODE);
    localparam logic OUT_SEC = out_on_sec(MODE);

    // Domain routing per register group (constant selects)
    logic rd_clk, rd_ce, rd_clr;
    logic o_clk,  o_ce,  o_clr;

    assign rd_clk = RD_SEC  ? clk_s : clk_p;
    assign rd_ce  = RD_SEC  ? ce_s  : ce_p;
    assign rd_clr = RD_SEC  ? clr_s : clr_p;
    assign o_clk  = OUT_SEC ? clk_s : clk_p;
    assign o_ce   = OUT_SEC ? ce_s  : ce_p;
    assign o_clr  = OUT_SEC ? clr_s : clr_p;

    logic              wq_en;
    logic [ADDR_W-1:0] wq_addr;
    logic [DATA_W-1:0] wq_data;
    logic [BE_W-1:0]   wq_be;
    logic              rq_en;
    logic [ADDR_W-1:0] rq_addr;
    logic [DATA_W-1:0] mem_word;

    sdpr_wr_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W)) u_wr (
        .clk(clk_p), .ce(ce_p), .clr(clr_p),
        .wen_i(wr_en), .hold_i(wr_addr_hold), .addr_i(wr_addr),
        .data_i(wr_data), .be_i(wr_lane_en),
        .wen_q(wq_en), .addr_q(wq_addr), .data_q(wq_data), .be_q(wq_be)
    );

    sdpr_rd_port #(.ADDR_W(ADDR_W)) u_rd (
        .clk(rd_clk), .ce(rd_ce), .clr(rd_clr),
        .ren_i(rd_en), .hold_i(rd_addr_hold), .addr_i(rd_addr),
        .ren_q(rq_en), .addr_q(rq_addr)
    );

    sdpr_lane_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W)) u_mem (
        .wclk(clk_p), .ce(ce_p), .we(wq_en), .waddr(wq_addr),
        .wdata(wq_data), .be(wq_be), .raddr(rq_addr), .rdata(mem_word)
    );

    sdpr_out_reg #(.DATA_W(DATA_W)) u_out (
        .clk(o_clk), .ce(o_ce), .clr(o_clr), .sclr(out_sclr),
        .load(rq_en), .d(mem_word), .q(rd_data)
    );

endmodule

// File: tb/sdp_ram_stall_tb.sv
module sdp_ram_stall_tb;
    import sdpr_pkg::*;

    localparam int AW = 6;
    localparam int DW = 32;
    localparam int BW = 4;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic ce_p, ce_s, clr_p, clr_s, out_sclr;
    logic [DW-1:0] wr_data;
    logic [AW-1:0] wr_addr, rd_addr;
    logic wr_en, wr_addr_hold, rd_en, rd_addr_hold;
    logic [BW-1:0] wr_lane_en;
    logic [DW-1:0] q_main, q_split;

    sdp_ram_stall #(.MODE(SDPR_SINGLE), .ADDR_W(AW), .DATA_W(DW), .BE_W(BW)) u_dut (
        .clk_p(clk), .clk_s(clk), .ce_p(ce_p), .ce_s(ce_s), .clr_p(clr_p), .clr_s(clr_s),
        .out_sclr(out_sclr), .wr_data(wr_data), .wr_addr(wr_addr), .wr_en(wr_en),
        .wr_lane_en(wr_lane_en), .wr_addr_hold(wr_addr_hold), .rd_addr(rd_addr),
        .rd_en(rd_en), .rd_addr_hold(rd_addr_hold), .rd_data(q_main)
    );

    sdp_ram_stall #(.MODE(SDPR_PER_PORT), .ADDR_W(AW), .DATA_W(DW), .BE_W(BW)) u_dut_split (
        .clk_p(clk), .clk_s(clk), .ce_p(ce_p), .ce_s(ce_s), .clr_p(clr_p), .clr_s(clr_s),
        .out_sclr(out_sclr), .wr_data(wr_data), .wr_addr(wr_addr), .wr_en(wr_en),
        .wr_lane_en(wr_lane_en), .wr_addr_hold(wr_addr_hold), .rd_addr(rd_addr),
        .rd_en(rd_en), .rd_addr_hold(rd_addr_hold), .rd_data(q_split)
    );

    // Reference model (single-clock behaviour)
    logic [DW-1:0] mmem [DEPTH];
    logic [AW-1:0] m_wa, m_ra;
    logic [DW-1:0] m_wd, mq;
    logic [BW-1:0] m_be;
    logic          m_we, m_re;

    int n_chk = 0;
    int n_bad = 0;

    function automatic logic [DW-1:0] fill_word(int a);
        return 32'hA55A0000 ^ (a * 32'h01030507);
    endfunction

    function automatic logic [DW-1:0] lane_merge(logic [DW-1:0] old_w,
                                                 logic [DW-1:0] new_w,
                                                 logic [BW-1:0] be);
        logic [DW-1:0] r = old_w;
        for (int i = 0; i < BW; i++) if (be[i]) r[i*8 +: 8] = new_w[i*8 +: 8];
        return r;
    endfunction

    task automatic model_clear();
        m_wa = '0; m_ra = '0; m_wd = '0; m_be = '0; m_we = 1'b0; m_re = 1'b0; mq = '0;
    endtask

    task automatic model_step();
        if (ce_p) begin
            if (out_sclr)  mq = '0;
            else if (m_re) mq = mmem[m_ra];
            if (m_we) mmem[m_wa] = lane_merge(mmem[m_wa], m_wd, m_be);
            if (!wr_addr_hold) m_wa = wr_addr;
            m_wd = wr_data; m_be = wr_lane_en; m_we = wr_en;
            if (!rd_addr_hold) m_ra = rd_addr;
            m_re = rd_en;
        end
    endtask

    task automatic check(string tag, logic [DW-1:0] got, logic [DW-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
        if (!clr_p) model_step();
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        wr_en = 0; wr_addr_hold = 0; rd_addr_hold = 0; rd_en = 0; out_sclr = 0;
        wr_lane_en = '1;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [DW-1:0] held;
        logic [31:0] seed_sink;
        seed_sink = $urandom(32'd4242);
        ce_p = 1; ce_s = 1; clr_p = 1; clr_s = 1;
        wr_data = '0; wr_addr = '0; rd_addr = '0;
        idle_inputs();
        model_clear();
        for (int a = 0; a < DEPTH; a++) mmem[a] = fill_word(a);
        repeat (2) @(negedge clk);
        // R11: clears force rd_data to zero
        check("R11 reset main", q_main, '0);
        check("R11 reset split", q_split, '0);
        clr_p = 0; clr_s = 0;
        @(negedge clk);

        // preload the storage with full-lane writes
        for (int a = 0; a < DEPTH; a++) begin
            wr_addr = AW'(a); wr_data = fill_word(a); wr_en = 1; wr_lane_en = '1;
            cyc();
        end
        idle_inputs();
        cyc();

        // R3: latency of one edge after the sampled strobe
        rd_addr = 6'd5; rd_en = 1;
        cyc();
        rd_en = 0;
        cyc();
        check("R3 read word", q_main, fill_word(5));
        check("R2 per-port read word", q_split, fill_word(5));

        // R5: read-during-write of the same address returns old contents
        wr_addr = 6'd7; wr_data = 32'hDEADBEEF; wr_en = 1; rd_addr = 6'd7; rd_en = 1;
        cyc();
        wr_en = 0;
        cyc();
        check("R5 old data", q_main, fill_word(7));
        cyc();
        check("R5 new data next", q_main, 32'hDEADBEEF);
        rd_en = 0;

        // R6: lane-masked write merges lanes 0 and 2
        wr_addr = 6'd3; wr_data = 32'h11223344; wr_lane_en = 4'b0101; wr_en = 1;
        cyc();
        wr_en = 0; wr_lane_en = '1; rd_addr = 6'd3; rd_en = 1;
        cyc(); cyc();
        check("R6 lane merge", q_main,
              {fill_word(3)[31:24], 8'h22, fill_word(3)[15:8], 8'h44});
        rd_en = 0;

        // R7: no strobe, no write
        wr_addr = 6'd10; wr_data = 32'h0BAD0BAD; wr_en = 0;
        cyc();
        rd_addr = 6'd10; rd_en = 1;
        cyc(); cyc();
        check("R7 word unchanged", q_main, fill_word(10));
        rd_en = 0;

        // R8: write address hold keeps address 20 while data changes
        wr_addr = 6'd20; wr_data = 32'h00000001; wr_en = 0;
        cyc();
        wr_addr = 6'd21; wr_addr_hold = 1; wr_data = 32'hCAFEF00D; wr_en = 1;
        cyc();
        wr_en = 0; wr_addr_hold = 0;
        rd_addr = 6'd20; rd_en = 1;
        cyc(); cyc();
        check("R8 held address written", q_main, 32'hCAFEF00D);
        rd_addr = 6'd21;
        cyc(); cyc();
        check("R8 new address untouched", q_main, fill_word(21));

        // R9: read address hold
        rd_addr = 6'd12; rd_en = 1;
        cyc();
        rd_addr = 6'd30; rd_addr_hold = 1;
        cyc(); cyc();
        check("R9 held read address", q_main, fill_word(12));
        rd_addr_hold = 0;

        // R4: strobe low keeps output
        rd_en = 0; rd_addr = 6'd40;
        cyc(); cyc(); cyc();
        check("R4 output held", q_main, fill_word(12));

        // R10: enable low blocks write and read updates
        ce_p = 0; ce_s = 0;
        wr_addr = 6'd40; wr_data = 32'h12345678; wr_en = 1; rd_en = 1;
        cyc(); cyc();
        check("R10 output frozen", q_main, fill_word(12));
        ce_p = 1; ce_s = 1; wr_en = 0; rd_en = 0;
        cyc();
        rd_en = 1;
        cyc(); cyc();
        check("R10 write blocked", q_main, fill_word(40));

        // R12: synchronous clear beats a pending read
        out_sclr = 1; rd_en = 1;
        cyc(); cyc();
        check("R12 sclr zero", q_main, '0);
        out_sclr = 0;
        cyc();
        check("R12 read resumes", q_main, mq);

        // R2 / R1: secondary enable and clear only affect the per-port instance
        rd_addr = 6'd50; rd_en = 1;
        cyc(); cyc();
        held = q_split;
        check("R2 per-port before gate", held, fill_word(50));
        ce_s = 0; rd_addr = 6'd51;
        cyc(); cyc();
        check("R2 secondary gate holds", q_split, held);
        check("R1 main ignores ce_s", q_main, fill_word(51));
        ce_s = 1; clr_s = 1;
        #1;
        check("R2 secondary clear", q_split, '0);
        cyc();
        check("R1 main ignores clr_s", q_main, mq);
        clr_s = 0;
        cyc(); cyc();
        check("R2 resync", q_split, mq);

        // R11: primary clear mid-run
        clr_p = 1;
        #1;
        model_clear();
        check("R11 mid-run clear", q_main, '0);
        cyc();
        clr_p = 0;
        cyc();
        check("R11 strobe cleared", q_main, mq);

        // Seeded random traffic against the model
        for (int k = 0; k < 3000; k++) begin
            wr_addr      = AW'($urandom);
            rd_addr      = AW'($urandom);
            wr_data      = $urandom;
            wr_lane_en   = BW'($urandom);
            wr_en        = ($urandom % 3) != 0;
            rd_en        = ($urandom % 4) != 0;
            wr_addr_hold = ($urandom % 5) == 0;
            rd_addr_hold = ($urandom % 5) == 0;
            out_sclr     = ($urandom % 40) == 0;
            ce_p         = ($urandom % 10) != 0;
            ce_s         = ce_p;
            cyc();
            check("R3 random main", q_main, mq);
            check("R2 random split", q_split, mq);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule